// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a small processor subsystem between four modes: run, wait, active-halt and full halt. The core asks to sleep with three request pulses: wait-for-interrupt, wait-for-event and halt. The controller checks each request against the interrupt and event enables, the pending interrupts, the wakeup-timer enable and the sensing-acquisition busy flag. It then gates the core clock, the peripheral clocks, the slow oscillator, flash power and the main regulator to match the mode it picks.

The controller also owns two small pieces of configuration. The first is the 2-bit system clock divider. It keeps its value through every sleep, so the clock restarts at the setting chosen before sleep. The second is an activation-level bit. While this bit is set, returning from an interrupt service routine sends the subsystem straight back to the low-power mode it woke from. Clearing the bit takes a short guard time to act. Every wake passes through a one-cycle stage in which the peripheral clocks run but the core clock does not.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run) and `sys_div` is 3 (divide by 8). Every enable output is 1 and `al_bit` is 0.
- R2: A write to `sys_div` (codes 0/1/2/3 give divide by 1/2/4/8) takes effect only while `mode` is 0 or 5. A write in any other mode is ignored. The value is kept unchanged through any sleep and wake.
- R3: In run, a wait-for-interrupt request enters mode 1 only if some `irq_enable` bit is set. A wait-for-event request enters mode 2 only if some `evt_enable` bit is set. A request that fails its check leaves the block in run. In modes 1 and 2 the core clock is 0 while peripheral clock, slow oscillator, flash and main regulator stay 1.
- R4: In mode 1, an enabled pending interrupt or `ext_irq` wakes the block into the service routine (mode 5).
- R5: In mode 2, an enabled event resumes run without a service routine, and it wins over a simultaneous interrupt. An interrupt runs the service routine. The return from that routine always goes back to mode 2, whatever the activation-level bit is.
- R6: A halt request in run with any `irq_pending` bit set leaves the block in run. Otherwise the block enters active-halt (mode 3) if `wkt_en` or `sense_busy` is 1, and full halt (mode 4) if neither is.
- R7: Full halt exits only on `ext_irq`. Active-halt exits on `ext_irq`, `wkt_irq` or `sense_done_irq`. Either exit leads to the service routine.
- R8: In modes 3 and 4, core clock, peripheral clock, flash power and main regulator are all 0. The slow oscillator is 0 only in mode 4.
- R9: Every wake passes through exactly one cycle of mode 6. In that cycle the peripheral clock, flash and regulator are 1 and the core clock is 0. The core clock rises in the next cycle.
- R10: `al_bit` is written only while `mode` is 0 or 5. On `isr_return` with `al_bit` set, the block goes back to the mode it woke from. With `al_bit` clear it goes to run. (A return to mode 2 follows R5 instead.)
- R11: A clear of `al_bit` counts for the return only when at least 2 cycles separate the clear from `isr_return`. A return in the cycle of the clear, or in the cycle right after it, still goes back to sleep.
- R12: When several requests arrive in the same run cycle, halt is served before wait-for-interrupt, and wait-for-interrupt before wait-for-event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse from the core |
| wfe_req | input | 1 | Wait-for-event request pulse from the core |
| halt_req | input | 1 | Halt request pulse from the core |
| irq_pending | input | NIRQ | Peripheral interrupt pending lines |
| irq_enable | input | NIRQ | Peripheral interrupt enables |
| ext_irq | input | 1 | External pin interrupt (always enabled) |
| evt_in | input | NEVT | Event lines |
| evt_enable | input | NEVT | Event enables |
| wkt_en | input | 1 | Wakeup timer is running |
| wkt_irq | input | 1 | Wakeup timer interrupt |
| sense_busy | input | 1 | Sensing acquisition in progress |
| sense_done_irq | input | 1 | Sensing-complete interrupt |
| isr_return | input | 1 | Core returns from a service routine |
| div_wr | input | 1 | Write strobe for the clock divider |
| div_sel | input | 2 | New divider code |
| al_wr | input | 1 | Write strobe for the activation-level bit |
| al_val | input | 1 | New activation-level value |
| mode | output | 3 | 0 run, 1 wfi, 2 wfe, 3 active-halt, 4 halt, 5 service routine, 6 wake |
| sys_div | output | 2 | Current divider code |
| al_bit | output | 1 | Current activation-level bit |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| slow_osc_en | output | 1 | Slow oscillator enable |
| flash_pwr_en | output | 1 | Flash power enable |
| mreg_en | output | 1 | Main regulator enable |

## Verification
The assertions watch several rules on every cycle. The core clock never rises unless the peripheral clock was already on. A halt request with a pending interrupt never leaves run. Halt with the timer or sensing busy always resolves to active-halt. Full halt holds until an external interrupt. The divider never changes while the core sleeps. A return from a service routine entered from wait-for-event always goes back to it. A fresh clear of the activation-level bit keeps the guard active for the next cycle. Other behaviours need whole sequences that only the bench scenarios build. These are the value of the divider after a complete sleep-and-wake round trip, the return to the mode the block woke from across several kinds of sleep, and the exact spacing between a clear of the activation-level bit and the interrupt return.

// File: rtl/lpm_pkg.sv
// Package: shared mode encoding for the low-power mode controller.
// Assumes the 3-bit code is visible at the top-level mode port.
package lpm_pkg;
    typedef enum logic [2:0] {
        M_RUN   = 3'd0,
        M_WFI   = 3'd1,
        M_WFE   = 3'd2,
        M_AHALT = 3'd3,
        M_HALT  = 3'd4,
        M_ISR   = 3'd5,
        M_WAKE  = 3'd6
    } lpm_mode_e;
endpackage

// File: rtl/lpm_wakesrc.sv
// Module: lpm_wakesrc
// Reduces the raw interrupt, event and timer lines to the few qualified
// conditions that the mode sequencer needs.
// Assumes every input is already synchronous to clk.
module lpm_wakesrc #(
    parameter int NIRQ = 4,
    parameter int NEVT = 4
) (
    input  logic [NIRQ-1:0] irq_pending,
    input  logic [NIRQ-1:0] irq_enable,
    input  logic            ext_irq,
    input  logic [NEVT-1:0] evt_in,
    input  logic [NEVT-1:0] evt_enable,
    input  logic            wkt_irq,
    input  logic            sense_done_irq,
    output logic            irq_hit,
    output logic            evt_hit,
    output logic            any_pending,
    output logic            any_irq_en,
    output logic            any_evt_en,
    output logic            ahalt_wake
);
    // Reduce the lines to qualified wake and entry conditions.
    always_comb begin
        irq_hit     = (|(irq_pending & irq_enable)) | ext_irq;
        evt_hit     = |(evt_in & evt_enable);
        any_pending = |irq_pending;
        any_irq_en  = |irq_enable;
        any_evt_en  = |evt_enable;
        ahalt_wake  = ext_irq | wkt_irq | sense_done_irq;
    end
endmodule

// File: rtl/lpm_fsm.sv
// Module: lpm_fsm
// Mode sequencer. It accepts sleep requests, resolves a halt into active-halt
// or full halt, sends each wake through one WAKE cycle, and on a service
// routine return picks between run and the mode the block woke from.
// Assumes the request pulses last one cycle and that isr_return is asserted
// only while the core runs a service routine.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wfi_req,
    input  logic      wfe_req,
    input  logic      halt_req,
    input  logic      wkt_en,
    input  logic      sense_busy,
    input  logic      isr_return,
    input  logic      irq_hit,
    input  logic      evt_hit,
    input  logic      any_pending,
    input  logic      any_irq_en,
    input  logic      any_evt_en,
    input  logic      ahalt_wake,
    input  logic      ext_irq,
    input  logic      al_eff,
    output lpm_mode_e state,
    output logic      core_run
);
    lpm_mode_e state_q, state_d;
    lpm_mode_e tgt_q, tgt_d;
    lpm_mode_e sleep_q, sleep_d;

    // Next-state selection for every mode.
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        sleep_d = sleep_q;
        case (state_q)
            M_RUN: begin
                if (halt_req) begin
                    if (!any_pending)
                        state_d = (wkt_en || sense_busy) ? M_AHALT : M_HALT;
                end else if (wfi_req && any_irq_en) begin
                    state_d = M_WFI;
                end else if (wfe_req && any_evt_en) begin
                    state_d = M_WFE;
                end
            end
            M_WFI: begin
                if (irq_hit) begin
                    state_d = M_WAKE;
                    tgt_d   = M_ISR;
                    sleep_d = M_WFI;
                end
            end
            M_WFE: begin
                if (evt_hit) begin
                    state_d = M_WAKE;
                    tgt_d   = M_RUN;
                end else if (irq_hit) begin
                    state_d = M_WAKE;
                    tgt_d   = M_ISR;
                    sleep_d = M_WFE;
                end
            end
            M_AHALT: begin
                if (ahalt_wake) begin
                    state_d = M_WAKE;
                    tgt_d   = M_ISR;
                    sleep_d = M_AHALT;
                end
            end
            M_HALT: begin
                if (ext_irq) begin
                    state_d = M_WAKE;
                    tgt_d   = M_ISR;
                    sleep_d = M_HALT;
                end
            end
            M_WAKE: state_d = tgt_q;
            M_ISR: begin
                if (isr_return) begin
                    if (sleep_q == M_WFE)  state_d = M_WFE;
                    else if (al_eff)       state_d = sleep_q;
                    else                   state_d = M_RUN;
                end
            end
            default: state_d = M_RUN;
        endcase
    end

    // State, wake target and saved sleep-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_RUN;
            tgt_q   <= M_RUN;
            sleep_q <= M_RUN;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            sleep_q <= sleep_d;
        end
    end

    assign state    = state_q;
    assign core_run = (state_q == M_RUN) || (state_q == M_ISR);

    // R6
    halt_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_RUN && halt_req && any_pending) |=> state_q == M_RUN);
    // R6
    ahalt_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_RUN && halt_req && !any_pending && (wkt_en || sense_busy))
        |=> state_q == M_AHALT);
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_HALT && !ext_irq) |=> state_q == M_HALT);
    // R5
    wfe_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_ISR && isr_return && sleep_q == M_WFE) |=> state_q == M_WFE);
    // R9
    wake_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_WAKE) |=> state_q != M_WAKE);
endmodule

// File: rtl/lpm_cfg.sv
// Module: lpm_cfg
// Holds the system clock divider and the activation-level bit. Writes are
// taken only while the core runs. A clear of the activation-level bit stays
// effective for AL_GUARD-1 more cycles, so a return that comes too soon after
// the clear still goes back to sleep.
// Assumes AL_GUARD >= 1.
module lpm_cfg #(
    parameter int DIV_W    = 2,
    parameter int AL_GUARD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_run,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             al_wr,
    input  logic             al_val,
    output logic [DIV_W-1:0] sys_div,
    output logic             al_bit,
    output logic             al_eff
);
    localparam int            GW    = (AL_GUARD > 1) ? $clog2(AL_GUARD) : 1;
    localparam logic [GW-1:0] GLOAD = GW'(AL_GUARD - 1);

    logic [GW-1:0] guard_q;
    logic          al_clear;

    assign al_clear = core_run && al_wr && !al_val && al_bit;

    // Divider register: resets to the slowest setting and changes only while the core runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sys_div <= {DIV_W{1'b1}};
        else if (core_run && div_wr) sys_div <= div_sel;
    end

    // Activation-level bit and the guard count that starts on its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_bit  <= 1'b0;
            guard_q <= '0;
        end else begin
            if (core_run && al_wr) al_bit <= al_val;
            if (al_clear)          guard_q <= GLOAD;
            else if (guard_q != '0) guard_q <= guard_q - 1'b1;
        end
    end

    assign al_eff = al_bit || (guard_q != '0);

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |=> $stable(sys_div));
    // R11
    al_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_clear |=> al_eff);
endmodule

// File: rtl/lpm_pwrdec.sv
// Module: lpm_pwrdec
// Turns the current mode into clock and power enables. It assumes each wake
// passes through M_WAKE, so the peripheral clock is on one cycle before the
// core clock.
module lpm_pwrdec
    import lpm_pkg::*;
(
    input  lpm_mode_e state,
    output logic      core_clk_en,
    output logic      periph_clk_en,
    output logic      slow_osc_en,
    output logic      flash_pwr_en,
    output logic      mreg_en
);
    logic deep;

    // Decode the enables from the mode.
    always_comb begin
        deep          = (state == M_AHALT) || (state == M_HALT);
        core_clk_en   = (state == M_RUN) || (state == M_ISR);
        periph_clk_en = !deep;
        slow_osc_en   = (state != M_HALT);
        flash_pwr_en  = !deep;
        mreg_en       = !deep;
    end
endmodule

// File: rtl/lpm_ctrl.sv
// Module: lpm_ctrl (top)
// Low-power mode controller. It joins the wake-source reduction, the mode
// sequencer, the configuration registers and the power decode.
// Assumes a single clock domain and a synchronous active-low reset.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NIRQ     = 4,
    parameter int NEVT     = 4,
    parameter int AL_GUARD = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wfi_req,
    input  logic            wfe_req,
    input  logic            halt_req,
    input  logic [NIRQ-1:0] irq_pending,
    input  logic [NIRQ-1:0] irq_enable,
    input  logic            ext_irq,
    input  logic [NEVT-1:0] evt_in,
    input  logic [NEVT-1:0] evt_enable,
    input  logic            wkt_en,
    input  logic            wkt_irq,
    input  logic            sense_busy,
    input  logic            sense_done_irq,
    input  logic            isr_return,
    input  logic            div_wr,
    input  logic [1:0]      div_sel,
    input  logic            al_wr,
    input  logic            al_val,
    output logic [2:0]      mode,
    output logic [1:0]      sys_div,
    output logic            al_bit,
    output logic            core_clk_en,
    output logic            periph_clk_en,
    output logic            slow_osc_en,
    output logic            flash_pwr_en,
    output logic            mreg_en
);
    logic      irq_hit, evt_hit, any_pending, any_irq_en, any_evt_en, ahalt_wake;
    logic      core_run, al_eff;
    lpm_mode_e state;

    lpm_wakesrc #(.NIRQ(NIRQ), .NEVT(NEVT)) u_wakesrc (
        .irq_pending(irq_pending), .irq_enable(irq_enable), .ext_irq(ext_irq),
        .evt_in(evt_in), .evt_enable(evt_enable), .wkt_irq(wkt_irq),
        .sense_done_irq(sense_done_irq), .irq_hit(irq_hit), .evt_hit(evt_hit),
        .any_pending(any_pending), .any_irq_en(any_irq_en),
        .any_evt_en(any_evt_en), .ahalt_wake(ahalt_wake)
    );

    lpm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .halt_req(halt_req), .wkt_en(wkt_en), .sense_busy(sense_busy),
        .isr_return(isr_return), .irq_hit(irq_hit), .evt_hit(evt_hit),
        .any_pending(any_pending), .any_irq_en(any_irq_en),
        .any_evt_en(any_evt_en), .ahalt_wake(ahalt_wake), .ext_irq(ext_irq),
        .al_eff(al_eff), .state(state), .core_run(core_run)
    );

    lpm_cfg #(.DIV_W(2), .AL_GUARD(AL_GUARD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .core_run(core_run), .div_wr(div_wr),
        .div_sel(div_sel), .al_wr(al_wr), .al_val(al_val), .sys_div(sys_div),
        .al_bit(al_bit), .al_eff(al_eff)
    );

    lpm_pwrdec u_pwrdec (
        .state(state), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .slow_osc_en(slow_osc_en), .flash_pwr_en(flash_pwr_en), .mreg_en(mreg_en)
    );

    assign mode = state;

    // R9
    core_after_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(periph_clk_en));
    // R8
    deep_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_clk_en) |-> (!core_clk_en && !flash_pwr_en && !mreg_en));
endmodule

// File: tb/lpm_ctrl_tb.sv
// Bench for lpm_ctrl. A behavioural model built from the requirements tracks
// the expected mode, divider and activation-level bit. Directed scenarios are
// followed by seeded random stimulus, and every cycle is compared.
module lpm_ctrl_tb;
    localparam int NIRQ = 4;
    localparam int NEVT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, halt_req = 0;
    logic [NIRQ-1:0] irq_pending = '0, irq_enable = '0;
    logic ext_irq = 0;
    logic [NEVT-1:0] evt_in = '0, evt_enable = '0;
    logic wkt_en = 0, wkt_irq = 0, sense_busy = 0, sense_done_irq = 0;
    logic isr_return = 0, div_wr = 0, al_wr = 0, al_val = 0;
    logic [1:0] div_sel = '0;
    logic [2:0] mode;
    logic [1:0] sys_div;
    logic al_bit, core_clk_en, periph_clk_en, slow_osc_en, flash_pwr_en, mreg_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_mode = 0, m_tgt = 0, m_sleep = 0, m_div = 3, m_guard = 0;
    bit m_al = 0;

    always #5 clk = ~clk;

    lpm_ctrl #(.NIRQ(NIRQ), .NEVT(NEVT), .AL_GUARD(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .halt_req(halt_req), .irq_pending(irq_pending), .irq_enable(irq_enable),
        .ext_irq(ext_irq), .evt_in(evt_in), .evt_enable(evt_enable),
        .wkt_en(wkt_en), .wkt_irq(wkt_irq), .sense_busy(sense_busy),
        .sense_done_irq(sense_done_irq), .isr_return(isr_return),
        .div_wr(div_wr), .div_sel(div_sel), .al_wr(al_wr), .al_val(al_val),
        .mode(mode), .sys_div(sys_div), .al_bit(al_bit),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .slow_osc_en(slow_osc_en), .flash_pwr_en(flash_pwr_en), .mreg_en(mreg_en)
    );

    // Expected enables {core, periph, slow, flash, mreg} for a mode (R3, R8, R9).
    function automatic logic [4:0] exp_en(int md);
        logic deep;
        deep = (md == 3) || (md == 4);
        return {(md == 0 || md == 5), !deep, (md != 4), !deep, !deep};
    endfunction

    // Advance the model by one clock edge using the current inputs.
    task automatic model_step();
        int  nm;
        bit  run, hit, ehit;
        nm   = m_mode;
        run  = (m_mode == 0) || (m_mode == 5);
        hit  = (|(irq_pending & irq_enable)) || ext_irq;
        ehit = |(evt_in & evt_enable);
        case (m_mode)
            0: if (halt_req) begin
                   if (irq_pending == '0) nm = (wkt_en || sense_busy) ? 3 : 4;
               end else if (wfi_req && irq_enable != '0) nm = 1;
               else if (wfe_req && evt_enable != '0) nm = 2;
            1: if (hit) begin nm = 6; m_tgt = 5; m_sleep = 1; end
            2: if (ehit) begin nm = 6; m_tgt = 0; end
               else if (hit) begin nm = 6; m_tgt = 5; m_sleep = 2; end
            3: if (ext_irq || wkt_irq || sense_done_irq) begin nm = 6; m_tgt = 5; m_sleep = 3; end
            4: if (ext_irq) begin nm = 6; m_tgt = 5; m_sleep = 4; end
            6: nm = m_tgt;
            5: if (isr_return) begin
                   if (m_sleep == 2) nm = 2;
                   else if (m_al || m_guard > 0) nm = m_sleep;
                   else nm = 0;
               end
            default: nm = 0;
        endcase
        if (run && al_wr && !al_val && m_al) m_guard = 1;
        else if (m_guard > 0) m_guard = m_guard - 1;
        if (run && div_wr) m_div = div_sel;
        if (run && al_wr) m_al = al_val;
        m_mode = nm;
    endtask

    task automatic compare(string tag);
        logic [10:0] act, exp;
        act = {mode, sys_div, al_bit, core_clk_en, periph_clk_en, slow_osc_en, flash_pwr_en, mreg_en};
        exp = {3'(m_mode), 2'(m_div), m_al, exp_en(m_mode)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {mode,div,al,core,per,slow,flash,mreg} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle();
        wfi_req = 0; wfe_req = 0; halt_req = 0; irq_pending = '0; ext_irq = 0;
        evt_in = '0; wkt_irq = 0; sense_done_irq = 0; isr_return = 0;
        div_wr = 0; al_wr = 0;
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk); #1;
        compare(tag);
        idle();
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        compare("R1 reset state");

        // R3: requests without enables are ignored
        wfi_req = 1; cyc("R3 wfi ignored");
        wfe_req = 1; cyc("R3 wfe ignored");
        // R2: divider write in run
        div_wr = 1; div_sel = 2'd1; cyc("R2 div write");
        // R3/R4: enter wfi, ignored divider write, wake to ISR
        irq_enable = 4'b0010; wfi_req = 1; cyc("R3 wfi entry");
        div_wr = 1; div_sel = 2'd0; cyc("R2 write ignored asleep");
        irq_pending = 4'b0001; cyc("R4 disabled irq no wake");
        irq_pending = 4'b0010; cyc("R9 wake stage");
        cyc("R4 isr entered");
        isr_return = 1; cyc("R10 return to run");
        // R5: wfe event and interrupt
        evt_enable = 4'b0100; wfe_req = 1; cyc("R5 wfe entry");
        evt_in = 4'b0100; irq_pending = 4'b0010; cyc("R5 event wins");
        cyc("R5 resume run");
        wfe_req = 1; cyc("R5 wfe again");
        irq_pending = 4'b0010; cyc("R5 irq wake");
        cyc("R5 isr");
        isr_return = 1; cyc("R5 back to wfe");
        evt_in = 4'b0100; cyc("R5 event"); cyc("R5 run");
        // R6: halt with pending / active-halt
        halt_req = 1; irq_pending = 4'b1000; cyc("R6 pending blocks halt");
        wkt_en = 1; halt_req = 1; cyc("R6 active-halt");
        cyc("R8 active-halt power");
        wkt_irq = 1; cyc("R7 timer wake"); cyc("R7 isr");
        isr_return = 1; cyc("R10 run");
        wkt_en = 0; sense_busy = 1; halt_req = 1; cyc("R6 sense active-halt");
        sense_done_irq = 1; cyc("R7 sense wake"); cyc("R7 isr");
        isr_return = 1; cyc("R10 run");
        sense_busy = 0; halt_req = 1; cyc("R6 full halt");
        wkt_irq = 1; cyc("R7 timer ignored in halt");
        sense_done_irq = 1; irq_pending = 4'b0010; cyc("R7 only ext wakes");
        ext_irq = 1; cyc("R9 wake from halt");
        cyc("R7 isr");
        // R10: activation level back to halt
        al_wr = 1; al_val = 1; cyc("R10 al set");
        isr_return = 1; cyc("R10 back to halt");
        ext_irq = 1; cyc("R9 wake"); cyc("R10 isr");
        // R11: clear and return same cycle
        al_wr = 1; al_val = 0; isr_return = 1; cyc("R11 same-cycle clear");
        ext_irq = 1; cyc("R9 wake"); cyc("R11 isr");
        al_wr = 1; al_val = 1; cyc("R11 set again");
        al_wr = 1; al_val = 0; cyc("R11 clear");
        isr_return = 1; cyc("R11 one cycle too soon");
        ext_irq = 1; cyc("R9 wake"); cyc("R11 isr");
        isr_return = 1; cyc("R11 guard elapsed to run");
        // R12: priority
        halt_req = 1; wfi_req = 1; wfe_req = 1; cyc("R12 halt first");
        ext_irq = 1; cyc("R9 wake"); cyc("R12 isr");
        isr_return = 1; cyc("R12 run");
        wfi_req = 1; wfe_req = 1; cyc("R12 wfi over wfe");
        ext_irq = 1; cyc("R4 ext wakes wfi"); cyc("R4 isr");
        isr_return = 1; cyc("R10 run");
        if (sys_div !== 2'd1) begin
            errors++; $display("FAIL R2 divider retained: actual=%0d expected=1", sys_div);
        end
        checks++;

        // Seeded random phase.
        for (int i = 0; i < 4000; i++) begin
            wfi_req        = ($urandom % 6) == 0;
            wfe_req        = ($urandom % 6) == 0;
            halt_req       = ($urandom % 6) == 0;
            irq_pending    = 4'(($urandom % 3) == 0 ? (1 << ($urandom % 4)) : 0);
            irq_enable     = 4'($urandom);
            ext_irq        = ($urandom % 10) == 0;
            evt_in         = 4'(($urandom % 3) == 0 ? (1 << ($urandom % 4)) : 0);
            evt_enable     = 4'($urandom);
            wkt_en         = ($urandom % 2) == 0;
            sense_busy     = ($urandom % 3) == 0;
            wkt_irq        = ($urandom % 8) == 0;
            sense_done_irq = ($urandom % 8) == 0;
            isr_return     = ($urandom % 3) == 0;
            div_wr         = ($urandom % 8) == 0;
            div_sel        = 2'($urandom);
            al_wr          = ($urandom % 4) == 0;
            al_val         = ($urandom % 2) == 0;
            cyc("R12 random mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule